// File: doc/BRIEF.md
# AHB-Lite to APB4 Width-Reducing Bridge

This block sits between an AHB-Lite manager and a single APB4 completer that share one clock. Each AHB transfer it accepts is turned into one or more APB4 accesses. The APB data bus may be narrower than the AHB data bus. In that case the AHB data word is cut into APB-wide segments. Only the segments that hold addressed bytes are visited, in ascending order, and each one gets its own setup and access phase.

On writes, each access carries the matching slice of the AHB write data and a byte strobe for the addressed bytes. On reads, the returned segments are placed back into their AHB byte lanes. The AHB side is held in wait states until the sequence ends. A completer error stops the sequence and is returned as a two-cycle AHB error response. The AHB protection attributes are mapped onto the APB protection bits.

Top module: `apb_narrow_bridge`

## Requirements
- R1: A transfer starts only when hsel is 1, hready is 1, hreadyout is 1 and htrans is NONSEQ (10) or SEQ (11). IDLE (00), BUSY (01), hsel low or hready low start nothing: psel stays 0 and hreadyout stays 1.
- R2: After a transfer is accepted, hreadyout is 0 while the APB sequence runs. One cycle after the final access completes without error, hreadyout is 1 and hresp is 0 (OKAY).
- R3: Each APB access has a first cycle with psel=1 and penable=0. This is followed by cycles with psel=1 and penable=1, with paddr held, until pready is sampled 1.
- R4: The byte count is 1<<hsize, limited to the AHB bus width. The start offset is the haddr byte offset within the AHB word, rounded down to that count. Only APB segments overlapping these bytes are accessed, in ascending order. paddr = (haddr with its AHB byte-offset bits cleared) + segment*APB bytes, truncated to PA_W bits.
- R5: On a write, pwrite=1, pwdata is the segment's slice of hwdata, and pstrb[n] is 1 exactly when byte n of the segment is addressed.
- R6: On a read, pwrite=0 and pstrb is all 0. prdata of each accessed segment appears in the matching hrdata lanes. Lanes that were not accessed read 0 in the completion cycle.
- R7: If pslverr is 1 when an access completes, the remaining segments are skipped. The response is then hreadyout=0 with hresp=1, followed by hreadyout=1 with hresp=1.
- R8: pprot[0] = hprot[1] (privileged), pprot[1] = 0 (secure), and pprot[2] = NOT hprot[0] (instruction when hprot[0]=0).
- R9: During and after reset: psel=0, penable=0, hreadyout=1, hresp=0.
- R10: A new transfer can be accepted in the cycle where the previous one completes, including the second error cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | AHB slave select |
| htrans | input | 2 | AHB transfer type |
| haddr | input | HA_W | AHB address |
| hwrite | input | 1 | AHB write (1) / read (0) |
| hsize | input | 3 | AHB transfer size, log2 bytes |
| hprot | input | 4 | AHB protection attributes |
| hwdata | input | HD_W | AHB write data (data phase) |
| hready | input | 1 | AHB bus ready |
| hrdata | output | HD_W | AHB read data |
| hreadyout | output | 1 | Slave ready / transfer done |
| hresp | output | 1 | Response, 1 = ERROR |
| psel | output | 1 | APB select |
| penable | output | 1 | APB access phase |
| pprot | output | 3 | APB protection |
| pwrite | output | 1 | APB write |
| pstrb | output | PD_W/8 | APB byte strobes |
| paddr | output | PA_W | APB address |
| pwdata | output | PD_W | APB write data |
| prdata | input | PD_W | APB read data |
| pready | input | 1 | APB completer ready |
| pslverr | input | 1 | APB completer error |

## Verification
The hardest situation to reach is an error in the middle of a multi-segment sequence. It must be shown that the later segments are never issued and that their bytes in the completer stay untouched. The bench arms its completer model to fault on one chosen APB address inside a word write, so the abort happens partway through the sequence. It then reads the whole word back and checks that the bytes after the fault still hold their old values. Wait states in the completer, and back-to-back AHB transfers started in the completion cycle, exercise the hold and handover edges.

// File: rtl/apb_bridge_pkg.sv
package apb_bridge_pkg;

   typedef enum logic [2:0] {
      BR_IDLE,
      BR_CAPT,
      BR_SETUP,
      BR_ACCESS,
      BR_ERR1,
      BR_ERR2
   } br_state_e;

   // AHB hprot -> APB pprot: {instruction, non-secure, privileged}
   function automatic logic [2:0] map_prot(input logic [1:0] hp_lo);
      return {~hp_lo[0], 1'b0, hp_lo[1]};
   endfunction

endpackage

// File: rtl/apb_bridge_lane_plan.sv
module apb_bridge_lane_plan #(
   parameter int HD_W = 32,
   parameter int PD_W = 8,
   localparam int HB     = HD_W / 8,
   localparam int PB     = PD_W / 8,
   localparam int LANES  = HD_W / PD_W,
   localparam int HB_LOG = $clog2(HB),
   localparam int OFF_W  = (HB_LOG > 0) ? HB_LOG : 1,
   localparam int SEG_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [OFF_W-1:0] addr_lo,
   input  logic [2:0]       size,
   output logic [HB-1:0]    byte_mask,
   output logic [SEG_W-1:0] seg_first,
   output logic [SEG_W-1:0] seg_last
);

   always_comb begin
      int sz;
      int nb;
      int off;
      sz = int'(size);
      if (sz > HB_LOG) sz = HB_LOG;
      nb  = 1 << sz;
      off = int'(addr_lo) % HB;
      off = off - (off % nb);
      for (int i = 0; i < HB; i++) begin
         byte_mask[i] = (i >= off) && (i < off + nb);
      end
      seg_first = SEG_W'(off / PB);
      seg_last  = SEG_W'((off + nb - 1) / PB);
   end

endmodule

// File: rtl/apb_bridge_wr_slice.sv
module apb_bridge_wr_slice #(
   parameter int HD_W = 32,
   parameter int PD_W = 8,
   localparam int HB    = HD_W / 8,
   localparam int PB    = PD_W / 8,
   localparam int LANES = HD_W / PD_W,
   localparam int SEG_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [HD_W-1:0]  wdata,
   input  logic [HB-1:0]    mask,
   input  logic             write,
   input  logic [SEG_W-1:0] seg,
   output logic [PD_W-1:0]  pwdata,
   output logic [PB-1:0]    pstrb
);

   generate
      if (LANES == 1) begin : g_same_width
         logic unused_seg;
         assign unused_seg = ^seg;
         assign pwdata = wdata;
         assign pstrb  = write ? mask : '0;
      end else begin : g_split
         always_comb begin
            pwdata = '0;
            pstrb  = '0;
            for (int k = 0; k < LANES; k++) begin
               if (seg == SEG_W'(k)) begin
                  pwdata = wdata[k*PD_W +: PD_W];
                  pstrb  = write ? mask[k*PB +: PB] : '0;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/apb_bridge_rd_gather.sv
module apb_bridge_rd_gather #(
   parameter int HD_W = 32,
   parameter int PD_W = 8,
   localparam int LANES = HD_W / PD_W,
   localparam int SEG_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [SEG_W-1:0] seg,
   input  logic [PD_W-1:0]  prdata,
   output logic [HD_W-1:0]  rdata
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [PD_W-1:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (clr) begin
            lane_q <= '0;
         end else if (load && (seg == SEG_W'(g))) begin
            lane_q <= prdata;
         end
      end
      assign rdata[g*PD_W +: PD_W] = lane_q;
   end

endmodule

// File: rtl/apb_bridge_ctrl.sv
module apb_bridge_ctrl
   import apb_bridge_pkg::*;
#(
   parameter int SEG_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SEG_W-1:0] seg_first,
   input  logic [SEG_W-1:0] seg_last,
   input  logic             pready,
   input  logic             pslverr,
   output logic             psel,
   output logic             penable,
   output logic             hreadyout,
   output logic             hresp,
   output logic             capt,
   output logic             beat_done,
   output logic [SEG_W-1:0] seg
);

   br_state_e state_q, state_d;
   logic [SEG_W-1:0] seg_d;

   always_comb begin
      state_d = state_q;
      seg_d   = seg;
      unique case (state_q)
         BR_IDLE:   if (start) state_d = BR_CAPT;
         BR_CAPT: begin
            seg_d   = seg_first;
            state_d = BR_SETUP;
         end
         BR_SETUP:  state_d = BR_ACCESS;
         BR_ACCESS: begin
            if (pready) begin
               if (pslverr) begin
                  state_d = BR_ERR1;
               end else if (seg == seg_last) begin
                  state_d = BR_IDLE;
               end else begin
                  seg_d   = seg + SEG_W'(1);
                  state_d = BR_SETUP;
               end
            end
         end
         BR_ERR1:   state_d = BR_ERR2;
         BR_ERR2:   state_d = start ? BR_CAPT : BR_IDLE;
         default:   state_d = BR_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BR_IDLE;
         seg     <= '0;
      end else begin
         state_q <= state_d;
         seg     <= seg_d;
      end
   end

   assign psel      = (state_q == BR_SETUP) || (state_q == BR_ACCESS);
   assign penable   = (state_q == BR_ACCESS);
   assign hreadyout = (state_q == BR_IDLE) || (state_q == BR_ERR2);
   assign hresp     = (state_q == BR_ERR1) || (state_q == BR_ERR2);
   assign capt      = (state_q == BR_CAPT);
   assign beat_done = penable && pready;

   // R2: the AHB side waits while an APB access is open
   a_r2_wait_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      psel |-> !hreadyout);

   // R3: setup cycle is followed by an access cycle
   a_r3_setup_then_access: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !penable) |=> (psel && penable));

   // R3: an access without pready stays on the same segment
   a_r3_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && !pready) |=> (psel && penable && $stable(seg)));

   // R7: error response is two cycles, the second one ready
   a_r7_error_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (hresp && !hreadyout) |=> (hresp && hreadyout));

   // R7: a faulting access ends the APB sequence
   a_r7_abort_on_error: assert property (@(posedge clk) disable iff (!rst_n)
      (penable && pready && pslverr) |=> (!psel && hresp));

endmodule

// File: rtl/apb_narrow_bridge.sv
module apb_narrow_bridge
   import apb_bridge_pkg::*;
#(
   parameter int HA_W = 32,
   parameter int HD_W = 32,
   parameter int PA_W = 10,
   parameter int PD_W = 8,
   localparam int HB     = HD_W / 8,
   localparam int PB     = PD_W / 8,
   localparam int LANES  = HD_W / PD_W,
   localparam int HB_LOG = $clog2(HB),
   localparam int PB_LOG = $clog2(PB),
   localparam int OFF_W  = (HB_LOG > 0) ? HB_LOG : 1,
   localparam int SEG_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hsel,
   input  logic [1:0]      htrans,
   input  logic [HA_W-1:0] haddr,
   input  logic            hwrite,
   input  logic [2:0]      hsize,
   input  logic [3:0]      hprot,
   input  logic [HD_W-1:0] hwdata,
   input  logic            hready,
   output logic [HD_W-1:0] hrdata,
   output logic            hreadyout,
   output logic            hresp,
   output logic            psel,
   output logic            penable,
   output logic [2:0]      pprot,
   output logic            pwrite,
   output logic [PB-1:0]   pstrb,
   output logic [PA_W-1:0] paddr,
   output logic [PD_W-1:0] pwdata,
   input  logic [PD_W-1:0] prdata,
   input  logic            pready,
   input  logic            pslverr
);

   // elaboration-time parameter checks
   generate
      if ((HD_W % 8) != 0 || (PD_W % 8) != 0)
         $error("bus widths must be whole bytes");
      if (PD_W > HD_W || (HD_W % PD_W) != 0)
         $error("APB width must divide the AHB width");
      if ((HB & (HB - 1)) != 0 || (PB & (PB - 1)) != 0)
         $error("byte counts must be powers of two");
      if (PA_W > HA_W || PA_W <= HB_LOG)
         $error("APB address width out of range");
   endgenerate

   logic             start;
   logic [HB-1:0]    mask_d, mask_q;
   logic [SEG_W-1:0] first_d, last_d, first_q, last_q, seg;
   logic [PA_W-1:0]  base_d, base_q;
   logic [HD_W-1:0]  wdata_q;
   logic             wr_q;
   logic [2:0]       prot_q;
   logic             capt, beat_done;
   logic             unused_ahb;

   assign unused_ahb = ^{haddr, hprot[3:2]};
   assign start = hreadyout && hready && hsel && htrans[1];

   apb_bridge_lane_plan #(.HD_W(HD_W), .PD_W(PD_W)) u_plan (
      .addr_lo   (haddr[OFF_W-1:0]),
      .size      (hsize),
      .byte_mask (mask_d),
      .seg_first (first_d),
      .seg_last  (last_d)
   );

   generate
      if (HB_LOG > 0) begin : g_base_align
         assign base_d = {haddr[PA_W-1:HB_LOG], HB_LOG'(0)};
      end else begin : g_base_plain
         assign base_d = haddr[PA_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         first_q <= '0;
         last_q  <= '0;
         base_q  <= '0;
         wr_q    <= 1'b0;
         prot_q  <= '0;
         wdata_q <= '0;
      end else begin
         if (start) begin
            mask_q  <= mask_d;
            first_q <= first_d;
            last_q  <= last_d;
            base_q  <= base_d;
            wr_q    <= hwrite;
            prot_q  <= map_prot(hprot[1:0]);
         end
         if (capt) wdata_q <= hwdata;
      end
   end

   apb_bridge_ctrl #(.SEG_W(SEG_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .seg_first (first_q),
      .seg_last  (last_q),
      .pready    (pready),
      .pslverr   (pslverr),
      .psel      (psel),
      .penable   (penable),
      .hreadyout (hreadyout),
      .hresp     (hresp),
      .capt      (capt),
      .beat_done (beat_done),
      .seg       (seg)
   );

   apb_bridge_wr_slice #(.HD_W(HD_W), .PD_W(PD_W)) u_wr (
      .wdata  (wdata_q),
      .mask   (mask_q),
      .write  (wr_q),
      .seg    (seg),
      .pwdata (pwdata),
      .pstrb  (pstrb)
   );

   apb_bridge_rd_gather #(.HD_W(HD_W), .PD_W(PD_W)) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (capt),
      .load   (beat_done && !wr_q),
      .seg    (seg),
      .prdata (prdata),
      .rdata  (hrdata)
   );

   assign paddr  = base_q + (PA_W'(seg) << PB_LOG);
   assign pwrite = wr_q;
   assign pprot  = prot_q;

   // R6: reads never raise a byte strobe
   a_r6_read_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !pwrite) |-> (pstrb == '0));

   // R4: consecutive accesses of one sequence step by the APB byte width
   a_r4_paddr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !penable && $past(psel && penable)) |-> (paddr == $past(paddr) + PA_W'(PB)));

   // R1: without a valid request the bridge stays idle and ready
   a_r1_ignore_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (hreadyout && !(hsel && htrans[1] && hready)) |=> (hreadyout && !hresp && !psel));

endmodule

// File: tb/tb_apb_narrow_bridge.sv
module tb_apb_narrow_bridge;

   localparam int CLK_PERIOD = 10;
   localparam int HA_W = 32;
   localparam int HD_W = 32;
   localparam int PA_W = 10;
   localparam int PD_W = 8;
   localparam int HB   = HD_W / 8;
   localparam int PB   = PD_W / 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hsel = 1'b0;
   logic [1:0] htrans = 2'b00;
   logic [HA_W-1:0] haddr = '0;
   logic hwrite = 1'b0;
   logic [2:0] hsize = 3'd0;
   logic [3:0] hprot = 4'd0;
   logic [HD_W-1:0] hwdata = '0;
   logic hready;
   logic hready_low = 1'b0;
   logic [HD_W-1:0] hrdata;
   logic hreadyout, hresp, psel, penable, pwrite;
   logic [2:0] pprot;
   logic [PB-1:0] pstrb;
   logic [PA_W-1:0] paddr;
   logic [PD_W-1:0] pwdata;
   logic [PD_W-1:0] prdata = '0;
   logic pready = 1'b0;
   logic pslverr = 1'b0;

   assign hready = hreadyout && !hready_low;

   always #(CLK_PERIOD/2) clk = ~clk;

   apb_narrow_bridge #(.HA_W(HA_W), .HD_W(HD_W), .PA_W(PA_W), .PD_W(PD_W)) dut (
      .clk(clk), .rst_n(rst_n), .hsel(hsel), .htrans(htrans), .haddr(haddr),
      .hwrite(hwrite), .hsize(hsize), .hprot(hprot), .hwdata(hwdata),
      .hready(hready), .hrdata(hrdata), .hreadyout(hreadyout), .hresp(hresp),
      .psel(psel), .penable(penable), .pprot(pprot), .pwrite(pwrite),
      .pstrb(pstrb), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr)
   );

   typedef struct packed {
      logic [PA_W-1:0] a;
      logic            w;
      logic [PB-1:0]   s;
      logic [PD_W-1:0] d;
      logic [2:0]      p;
   } acc_t;

   acc_t exp_q[$];
   logic [7:0] pmem [0:(1<<PA_W)-1];
   int   errors = 0;
   int   checks = 0;
   int   wait_n = 0;
   int   wcnt = 0;
   bit   err_en = 1'b0;
   logic [PA_W-1:0] err_addr = '0;
   bit   hold_prev = 1'b0;
   logic [PA_W-1:0] prev_pa = '0;
   int   cyc = 0;
   bit   done = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // completer model and cycle-by-cycle monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_prev)
            chk(psel && penable && paddr == prev_pa, "R3 access follows and holds paddr",
                {psel, penable, paddr}, {2'b11, prev_pa});
         if (psel)
            chk(!hreadyout, "R2 hreadyout low during APB", 64'(hreadyout), 64'd0);
         pready  = 1'b0;
         pslverr = 1'b0;
         if (psel && penable) begin
            if (wcnt >= wait_n) begin
               acc_t e;
               pready  = 1'b1;
               prdata  = pmem[paddr];
               pslverr = err_en && (paddr == err_addr);
               wcnt = 0;
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R4 unexpected APB access", 64'(paddr), 64'd0);
               end else begin
                  e = exp_q.pop_front();
                  chk(paddr == e.a, "R4 paddr", 64'(paddr), 64'(e.a));
                  chk(pwrite == e.w, "R5 pwrite", 64'(pwrite), 64'(e.w));
                  chk(pstrb == e.s, "R5/R6 pstrb", 64'(pstrb), 64'(e.s));
                  if (e.w) chk(pwdata == e.d, "R5 pwdata", 64'(pwdata), 64'(e.d));
                  chk(pprot == e.p, "R8 pprot", 64'(pprot), 64'(e.p));
               end
               if (pwrite && !pslverr) pmem[paddr] = pwdata;
            end else begin
               wcnt++;
            end
         end
         hold_prev = psel && !(penable && pready);
         prev_pa   = paddr;
      end
   end

   task automatic summary_and_end();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog expired act=%0d exp=0", cyc);
         summary_and_end();
      end
   end

   // one AHB transfer; starts and ends at a negedge with hreadyout high
   task automatic ahb_xfer(input bit wr, input logic [HA_W-1:0] addr, input logic [2:0] sz,
                           input logic [HD_W-1:0] wd, input logic [3:0] prot, input string tag);
      int s, nb, off, n;
      logic [PA_W-1:0] base, pa;
      logic [HD_W-1:0] exp_rd;
      bit exp_err, saw_e1;
      acc_t e;
      s = (int'(sz) > $clog2(HB)) ? $clog2(HB) : int'(sz);
      nb = 1 << s;
      off = int'(addr % HB);
      off = off - (off % nb);
      base = addr[PA_W-1:0] & ~PA_W'(HB - 1);
      exp_rd = '0;
      exp_err = 1'b0;
      for (int b = off; b < off + nb; b++) begin
         pa = base + PA_W'(b);
         e.a = pa;
         e.w = wr;
         e.s = wr ? PB'(1) : '0;
         e.d = wd[8*b +: 8];
         e.p = {~prot[0], 1'b0, prot[1]};
         exp_q.push_back(e);
         if (!wr) exp_rd[8*b +: 8] = pmem[pa];
         if (err_en && pa == err_addr) begin
            exp_err = 1'b1;
            break;
         end
      end
      hsel = 1'b1; htrans = 2'b10; haddr = addr; hwrite = wr; hsize = sz; hprot = prot;
      @(negedge clk);
      hsel = 1'b0; htrans = 2'b00; hwdata = wd;
      saw_e1 = 1'b0;
      n = 0;
      while (!hreadyout && n < 2000) begin
         if (hresp) saw_e1 = 1'b1;
         @(negedge clk);
         n++;
      end
      chk(hresp == exp_err, {tag, " R2/R7 hresp at completion"}, 64'(hresp), 64'(exp_err));
      if (exp_err) chk(saw_e1, {tag, " R7 first error cycle"}, 64'(saw_e1), 64'd1);
      if (!wr && !exp_err) chk(hrdata == exp_rd, {tag, " R6 hrdata"}, 64'(hrdata), 64'(exp_rd));
      chk(exp_q.size() == 0, {tag, " R4 all segments issued"}, 64'(exp_q.size()), 64'd0);
      exp_q.delete();
   endtask

   task automatic idle_probe(input bit s, input logic [1:0] t, input bit hr_low, input string tag);
      hsel = s; htrans = t; hready_low = hr_low; haddr = 32'h0000_0040; hwrite = 1'b1;
      @(negedge clk);
      hsel = 1'b0; htrans = 2'b00; hready_low = 1'b0;
      for (int i = 0; i < 3; i++) begin
         chk(!psel && hreadyout, {tag, " R1 no transfer started"}, {psel, hreadyout}, 64'b01);
         @(negedge clk);
      end
   endtask

   initial begin
      for (int i = 0; i < (1 << PA_W); i++) pmem[i] = 8'(i * 7 + 3);
      repeat (3) @(negedge clk);
      chk(!psel && !penable && hreadyout && !hresp, "R9 reset state",
          {psel, penable, hreadyout, hresp}, 64'b0010);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!psel && !penable && hreadyout && !hresp, "R9 after reset",
          {psel, penable, hreadyout, hresp}, 64'b0010);

      idle_probe(1'b0, 2'b10, 1'b0, "hsel low");
      idle_probe(1'b1, 2'b00, 1'b0, "IDLE");
      idle_probe(1'b1, 2'b01, 1'b0, "BUSY");
      idle_probe(1'b1, 2'b10, 1'b1, "hready low");

      wait_n = 0;
      ahb_xfer(1'b1, 32'h0000_0100, 3'd2, 32'hA1B2_C3D4, 4'b0011, "word write R5");
      wait_n = 2;
      ahb_xfer(1'b0, 32'h0000_0100, 3'd2, 32'h0, 4'b0000, "word read R6");
      wait_n = 1;
      ahb_xfer(1'b1, 32'h0000_0205, 3'd0, 32'h1122_3344, 4'b0010, "byte write R5");
      ahb_xfer(1'b0, 32'h0000_0206, 3'd1, 32'h0, 4'b0001, "half read R6");
      wait_n = 0;
      ahb_xfer(1'b0, 32'h0000_1404, 3'd2, 32'h0, 4'b0011, "high addr truncation R4");
      ahb_xfer(1'b1, 32'h0000_0080, 3'd3, 32'hDEAD_BEEF, 4'b0011, "size above bus R4");
      ahb_xfer(1'b0, 32'h0000_0082, 3'd3, 32'h0, 4'b0011, "size above bus read R4");

      // R7: fault in the middle of a word write, later byte must stay untouched
      err_en = 1'b1; err_addr = 10'h302; wait_n = 1;
      ahb_xfer(1'b1, 32'h0000_0300, 3'd2, 32'h5566_7788, 4'b0011, "mid error R7");
      // R10: next transfer issued right in the second error cycle
      err_en = 1'b0;
      ahb_xfer(1'b0, 32'h0000_0300, 3'd2, 32'h0, 4'b0011, "readback after error R7 R10");
      chk(hrdata[31:24] == 8'(32'h303 * 7 + 3), "R7 skipped byte unchanged",
          64'(hrdata[31:24]), 64'(8'(32'h303 * 7 + 3)));

      err_en = 1'b1; err_addr = 10'h310; wait_n = 0;
      ahb_xfer(1'b0, 32'h0000_0310, 3'd0, 32'h0, 4'b0000, "read error R7");
      err_en = 1'b0;
      ahb_xfer(1'b1, 32'h0000_0311, 3'd0, 32'h0000_AB00, 4'b0001, "after read error R10");

      repeat (3) @(negedge clk);
      done = 1'b1;
      summary_and_end();
   end

endmodule